// File: doc/BRIEF.md
# Power Management Function Decoder

This block sits behind a configuration-space write port and turns a few configuration registers into two relocatable I/O windows: a 128-byte power-management window and a 16-byte SMBus window. Each incoming I/O request is matched against both windows and a hit is raised for each window that claims it. Software moves a window by writing its base register and opens it with an enable bit that lives in a separate register. Every base write is reformatted on the way in: the alignment bits are cleared and bit 0 is forced to 1.

The block also drives the level-sensitive system control interrupt. It combines the PM1 event status and PM1 enable words, which enter as inputs, over the four interrupt-capable event sources. It also reports when the overflow event of the power-management timer should be armed. A design parameter states whether the function has an interrupt pin. Without one, the interrupt line is held low.

Configuration accesses are 32 bits wide and use a dword index plus four byte enables. The read data is a combinational view of the dword the index selects.

Top module: `pmfd_top`

## Requirements
- R1: After reset, dword 0x48 and dword 0x90 read 0x00000001, dword 0x40 and dword 0xD0 read 0, and neither window hits.
- R2: A write to any byte of dword 0x48 first merges the enabled bytes into the current value. The stored value then becomes (merged AND 0xFF80) OR 1, so bits 31:16 and 6:1 read 0 and bit 0 reads 1.
- R3: A write to any byte of dword 0x90 stores (merged AND 0xFFF0) OR 1 in the same way.
- R4: Configuration byte 0xD2 is dword 0xD0, byte lane 2. A write to it keeps only its low four bits. The other lanes of that dword read 0.
- R5: Byte 0x41 is dword 0x40, byte lane 1, and is fully writable. pm_hit is 1 when all of these hold: byte 0x41 bit 7 is set, io_req is 1, io_single is 1, and io_addr AND 0xFF80 equals the PM base.
- R6: A request with io_single at 0 (a multi-byte access) never raises pm_hit.
- R7: smb_hit is 1 when byte 0xD2 bit 0 is set, io_req is 1, and io_addr AND 0xFFF0 equals the SMBus base, whatever the access width.
- R8: Hits are combinational from io_addr and the current registers. A configuration write changes the read data and the hits from the cycle after the clock edge that captures it.
- R9: With HAS_IRQ_PIN nonzero, sci is 1 when (pm1_sts AND pm1_en) has any of bits 10, 8, 5 or 0 set. Other bits have no effect.
- R10: With HAS_IRQ_PIN at 0, sci stays 0 for every status and enable value.
- R11: tmr_arm is 1 exactly when pm1_en bit 0 is 1 and pm1_sts bit 0 is 0.
- R12: Writes to dwords other than 0x40, 0x48, 0x90 and 0xD0 are ignored and those dwords read 0. Lanes with a byte enable of 0 leave their byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_dw | input | 6 | Dword index (byte offset divided by 4) |
| cfg_be | input | 4 | Byte enables, bit n covers lane n |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Read view of the indexed dword |
| io_req | input | 1 | I/O request valid |
| io_single | input | 1 | 1 when the access is a single byte |
| io_addr | input | 16 | I/O address |
| pm_hit | output | 1 | Request claimed by the PM window |
| smb_hit | output | 1 | Request claimed by the SMBus window |
| pm1_sts | input | 16 | PM1 event status word |
| pm1_en | input | 16 | PM1 event enable word |
| sci | output | 1 | System control interrupt level |
| tmr_arm | output | 1 | Timer overflow event should be armed |

## Verification
Assertions check on every cycle that a hit never appears without its window enable, that pm_hit never answers a multi-byte request, that the bases only move on a configuration write, and that sci and tmr_arm agree with the status and enable words they depend on. Only the bench's scenarios can show the exact values stored after masked and partial-lane writes, the window edges one byte inside and outside each range, the one-cycle latency from a write to a hit, and the silent interrupt line of a function without an interrupt pin.

// File: rtl/pmfd_pkg.sv
package pmfd_pkg;
  localparam int unsigned ADDR_W   = 16;
  localparam int unsigned PM_BYTES = 128;
  localparam int unsigned SMB_BYTES = 16;

  localparam logic [5:0] DW_CTL   = 6'h10; // 0x40, control byte in lane 1
  localparam logic [5:0] DW_PMB   = 6'h12; // 0x48
  localparam logic [5:0] DW_SMBB  = 6'h24; // 0x90
  localparam logic [5:0] DW_SMCTL = 6'h34; // 0xD0, SMBus control in lane 2

  localparam logic [15:0] SCI_SRC = 16'h0521; // bits 10, 8, 5, 0

  function automatic logic [31:0] lane_merge(input logic [31:0] old_v,
                                             input logic [31:0] new_v,
                                             input logic [3:0]  be);
    logic [31:0] r;
    for (int i = 0; i < 4; i++)
      r[i*8 +: 8] = be[i] ? new_v[i*8 +: 8] : old_v[i*8 +: 8];
    return r;
  endfunction

  function automatic logic [31:0] base_fmt(input logic [31:0] v,
                                           input int unsigned win_bytes);
    logic [31:0] m;
    m = 32'h0000_FFFF & ~(32'(win_bytes) - 32'd1);
    return (v & m) | 32'd1;
  endfunction
endpackage

// File: rtl/pmfd_cfg.sv
module pmfd_cfg
  import pmfd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [5:0]  cfg_dw,
  input  logic [3:0]  cfg_be,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  output logic [31:0] pm_base,
  output logic [31:0] smb_base,
  output logic        pm_en,
  output logic        smb_en
);
  logic [7:0] ctl_q;
  logic [3:0] smctl_q;
  logic [31:0] merged;

  assign merged = lane_merge(cfg_rdata, cfg_wdata, cfg_be);

  always_comb begin
    case (cfg_dw)
      DW_CTL:   cfg_rdata = {16'h0, ctl_q, 8'h0};
      DW_PMB:   cfg_rdata = pm_base;
      DW_SMBB:  cfg_rdata = smb_base;
      DW_SMCTL: cfg_rdata = {12'h0, smctl_q, 16'h0};
      default:  cfg_rdata = 32'h0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q    <= 8'h0;
      smctl_q  <= 4'h0;
      pm_base  <= 32'd1;
      smb_base <= 32'd1;
    end else if (cfg_we) begin
      case (cfg_dw)
        DW_CTL:   ctl_q    <= merged[15:8];
        DW_PMB:   pm_base  <= base_fmt(merged, PM_BYTES);
        DW_SMBB:  smb_base <= base_fmt(merged, SMB_BYTES);
        DW_SMCTL: smctl_q  <= merged[19:16];
        default:  ;
      endcase
    end
  end

  assign pm_en  = ctl_q[7];
  assign smb_en = smctl_q[0];

  a_r8_bases_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> ($stable(pm_base) && $stable(smb_base)));
  a_r2_pm_base_form: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_dw == DW_PMB) |=> (pm_base[0] && pm_base[31:16] == 16'h0));
endmodule

// File: rtl/pmfd_window.sv
module pmfd_window #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned WIN_BYTES = 128,
  parameter bit          NEED_SINGLE = 1'b1,
  localparam int unsigned OFS_W    = $clog2(WIN_BYTES),
  localparam int unsigned TAG_W    = ADDR_W - OFS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             req,
  input  logic             single,
  input  logic [TAG_W-1:0] base_tag,
  input  logic [TAG_W-1:0] addr_tag,
  output logic             hit
);
  logic size_ok;

  generate
    if (NEED_SINGLE) begin : g_single
      assign size_ok = single;
    end else begin : g_any
      assign size_ok = 1'b1;
    end
  endgenerate

  assign hit = en && req && size_ok && (addr_tag == base_tag);

  a_r5_hit_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (en && req));
  a_r6_single_only: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && NEED_SINGLE) |-> single);
endmodule

// File: rtl/pmfd_sci.sv
module pmfd_sci
  import pmfd_pkg::*;
#(
  parameter bit HAS_IRQ_PIN = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] pm1_sts,
  input  logic [15:0] pm1_en,
  output logic        sci,
  output logic        tmr_arm
);
  logic [15:0] pending;
  logic        level;

  assign pending = pm1_sts & pm1_en & SCI_SRC;
  assign level   = |pending;

  generate
    if (HAS_IRQ_PIN) begin : g_pin
      assign sci = level;
    end else begin : g_nopin
      assign sci = 1'b0;
    end
  endgenerate

  assign tmr_arm = pm1_en[0] & ~pm1_sts[0];

  a_r9_sci_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    sci |-> ((pm1_sts[10] && pm1_en[10]) || (pm1_sts[8] && pm1_en[8]) ||
             (pm1_sts[5] && pm1_en[5]) || (pm1_sts[0] && pm1_en[0])));
  a_r10_no_pin_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !HAS_IRQ_PIN |-> !sci);
  a_r11_arm_rule: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_arm |-> (!pm1_sts[0] && pm1_en[0]));
endmodule

// File: rtl/pmfd_top.sv
module pmfd_top
  import pmfd_pkg::*;
#(
  parameter bit HAS_IRQ_PIN = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [5:0]  cfg_dw,
  input  logic [3:0]  cfg_be,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        io_req,
  input  logic        io_single,
  input  logic [15:0] io_addr,
  output logic        pm_hit,
  output logic        smb_hit,
  input  logic [15:0] pm1_sts,
  input  logic [15:0] pm1_en,
  output logic        sci,
  output logic        tmr_arm
);
  localparam int unsigned PM_OFS  = $clog2(PM_BYTES);
  localparam int unsigned SMB_OFS = $clog2(SMB_BYTES);

  logic [31:0] pm_base, smb_base;
  logic        pm_en, smb_en;

  pmfd_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_dw(cfg_dw),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .pm_base(pm_base), .smb_base(smb_base), .pm_en(pm_en), .smb_en(smb_en)
  );

  pmfd_window #(.ADDR_W(ADDR_W), .WIN_BYTES(PM_BYTES), .NEED_SINGLE(1'b1)) u_pm_win (
    .clk(clk), .rst_n(rst_n), .en(pm_en), .req(io_req), .single(io_single),
    .base_tag(pm_base[ADDR_W-1:PM_OFS]), .addr_tag(io_addr[ADDR_W-1:PM_OFS]),
    .hit(pm_hit)
  );

  pmfd_window #(.ADDR_W(ADDR_W), .WIN_BYTES(SMB_BYTES), .NEED_SINGLE(1'b0)) u_smb_win (
    .clk(clk), .rst_n(rst_n), .en(smb_en), .req(io_req), .single(io_single),
    .base_tag(smb_base[ADDR_W-1:SMB_OFS]), .addr_tag(io_addr[ADDR_W-1:SMB_OFS]),
    .hit(smb_hit)
  );

  pmfd_sci #(.HAS_IRQ_PIN(HAS_IRQ_PIN)) u_sci (
    .clk(clk), .rst_n(rst_n), .pm1_sts(pm1_sts), .pm1_en(pm1_en),
    .sci(sci), .tmr_arm(tmr_arm)
  );

  a_r1_idle_after_reset: assert property (@(posedge clk)
    $past(!rst_n) |-> (!pm_hit && !smb_hit));
  a_r7_smb_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    smb_hit |-> io_req);
endmodule

// File: tb/pmfd_top_test.sv
`timescale 1ns/1ps
module pmfd_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_dw = 6'h0;
  logic [3:0]  cfg_be = 4'h0;
  logic [31:0] cfg_wdata = 32'h0;
  logic [31:0] cfg_rdata, np_rdata;
  logic        io_req = 1'b0, io_single = 1'b0;
  logic [15:0] io_addr = 16'h0;
  logic        pm_hit, smb_hit, sci, tmr_arm;
  logic        np_pm_hit, np_smb_hit, np_sci, np_tmr_arm;
  logic [15:0] pm1_sts = 16'h0, pm1_en = 16'h0;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pmfd_top #(.HAS_IRQ_PIN(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_dw(cfg_dw), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .io_req(io_req),
    .io_single(io_single), .io_addr(io_addr), .pm_hit(pm_hit), .smb_hit(smb_hit),
    .pm1_sts(pm1_sts), .pm1_en(pm1_en), .sci(sci), .tmr_arm(tmr_arm));

  pmfd_top #(.HAS_IRQ_PIN(1'b0)) uut_nopin (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_dw(cfg_dw), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(np_rdata), .io_req(io_req),
    .io_single(io_single), .io_addr(io_addr), .pm_hit(np_pm_hit), .smb_hit(np_smb_hit),
    .pm1_sts(pm1_sts), .pm1_en(pm1_en), .sci(np_sci), .tmr_arm(np_tmr_arm));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [5:0] dw, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_dw = dw; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_be = 4'h0;
  endtask

  task automatic cfg_expect(input string req, input logic [5:0] dw, input logic [31:0] exp);
    cfg_dw = dw; #1;
    check(req, cfg_rdata, exp);
  endtask

  task automatic io_probe(input string req, input logic r, input logic s,
                          input logic [15:0] a, input logic exp_pm, input logic exp_smb);
    io_req = r; io_single = s; io_addr = a; #1;
    check({req, " pm_hit"}, 32'(pm_hit), 32'(exp_pm));
    check({req, " smb_hit"}, 32'(smb_hit), 32'(exp_smb));
  endtask

  task automatic t_reset;
    cfg_expect("R1 pm base", 6'h12, 32'h1);
    cfg_expect("R1 smb base", 6'h24, 32'h1);
    cfg_expect("R1 ctl", 6'h10, 32'h0);
    cfg_expect("R1 smctl", 6'h34, 32'h0);
    io_probe("R1 closed", 1'b1, 1'b1, 16'h0000, 1'b0, 1'b0);
  endtask

  task automatic t_pm_base;
    cfg_write(6'h12, 4'hF, 32'hABCD_1234);
    cfg_expect("R2 full write", 6'h12, 32'h0000_1201);
    cfg_write(6'h12, 4'h2, 32'h0000_5600);
    cfg_expect("R2 lane1 write", 6'h12, 32'h0000_5601);
    cfg_write(6'h12, 4'h1, 32'h0000_00FF);
    cfg_expect("R2 lane0 write", 6'h12, 32'h0000_5681);
  endtask

  task automatic t_pm_window;
    io_req = 1'b1; io_single = 1'b1; io_addr = 16'h5680;
    @(negedge clk);
    cfg_we = 1'b1; cfg_dw = 6'h10; cfg_be = 4'h2; cfg_wdata = 32'h0000_8000;
    #1 check("R8 before edge", 32'(pm_hit), 32'd0);
    @(negedge clk);
    cfg_we = 1'b0; cfg_be = 4'h0;
    #1 check("R8 after edge", 32'(pm_hit), 32'd1);
    cfg_expect("R5 ctl readback", 6'h10, 32'h0000_8000);
    io_probe("R5 low edge", 1'b1, 1'b1, 16'h5680, 1'b1, 1'b0);
    io_probe("R5 high edge", 1'b1, 1'b1, 16'h56FF, 1'b1, 1'b0);
    io_probe("R5 below", 1'b1, 1'b1, 16'h567F, 1'b0, 1'b0);
    io_probe("R5 above", 1'b1, 1'b1, 16'h5700, 1'b0, 1'b0);
    io_probe("R5 no req", 1'b0, 1'b1, 16'h5690, 1'b0, 1'b0);
    io_probe("R6 multi-byte", 1'b1, 1'b0, 16'h5690, 1'b0, 1'b0);
  endtask

  task automatic t_smb;
    cfg_write(6'h24, 4'hF, 32'h1234_ABCD);
    cfg_expect("R3 smb base", 6'h24, 32'h0000_ABC1);
    cfg_write(6'h34, 4'h4, 32'h00FF_0000);
    cfg_expect("R4 nibble kept", 6'h34, 32'h000F_0000);
    io_probe("R7 low edge", 1'b1, 1'b1, 16'hABC0, 1'b0, 1'b1);
    io_probe("R7 high edge wide", 1'b1, 1'b0, 16'hABCF, 1'b0, 1'b1);
    io_probe("R7 above", 1'b1, 1'b1, 16'hABD0, 1'b0, 1'b0);
    io_probe("R7 below", 1'b1, 1'b1, 16'hABBF, 1'b0, 1'b0);
    cfg_write(6'h34, 4'hF, 32'hFFFE_FFFF);
    cfg_expect("R4 other lanes zero", 6'h34, 32'h000E_0000);
    io_probe("R7 disabled", 1'b1, 1'b1, 16'hABC0, 1'b0, 1'b0);
  endtask

  task automatic t_ignored;
    cfg_write(6'h11, 4'hF, 32'hFFFF_FFFF);
    cfg_expect("R12 unmodeled reads 0", 6'h11, 32'h0);
    cfg_expect("R12 pm base untouched", 6'h12, 32'h0000_5681);
    cfg_write(6'h10, 4'hD, 32'hFFFF_00FF);
    cfg_expect("R12 lane1 kept", 6'h10, 32'h0000_8000);
    cfg_write(6'h12, 4'h0, 32'hFFFF_FFFF);
    cfg_expect("R12 no lanes", 6'h12, 32'h0000_5681);
  endtask

  task automatic sci_case(input string req, input logic [15:0] s, input logic [15:0] e,
                          input logic exp_sci, input logic exp_arm);
    pm1_sts = s; pm1_en = e; #1;
    check({req, " sci"}, 32'(sci), 32'(exp_sci));
    check("R10 no pin sci", 32'(np_sci), 32'd0);
    check("R11 tmr_arm", 32'(tmr_arm), 32'(exp_arm));
  endtask

  task automatic t_sci;
    sci_case("R9 rtc", 16'h0400, 16'h0400, 1'b1, 1'b0);
    sci_case("R9 power button", 16'h0100, 16'h0100, 1'b1, 1'b0);
    sci_case("R9 non-source bit", 16'h0002, 16'h0002, 1'b0, 1'b0);
    sci_case("R9 lock", 16'h0120, 16'h0020, 1'b1, 1'b0);
    sci_case("R9 masked timer", 16'h0001, 16'h0000, 1'b0, 1'b0);
    sci_case("R9 timer", 16'h0001, 16'h0001, 1'b1, 1'b0);
    sci_case("R11 armed", 16'h0000, 16'h0001, 1'b0, 1'b1);
    sci_case("R9 all off", 16'hFFFF, 16'h0000, 1'b0, 1'b0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      done = 1'b1;
      fails++; checks++;
      $display("FAIL watchdog: actual %0d cycles expected under 5000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pm_base();
    t_pm_window();
    t_smb();
    t_ignored();
    t_sci();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule